// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block merges the interrupt events of a small processor's surroundings into one request line for a core that has a single interrupt vector. Three core sources keep their flags and enables in a main control register. Twelve peripheral sources keep their flags in two request registers and their enables in two matching enable registers. The enables form a hierarchy. A global enable sits above everything. Below it, a peripheral enable acts as a second-level global switch for the peripheral group. Below that, each source has its own enable.

A flag is set by a one-cycle event pulse from its source, whatever the state of its enable bit, so software can also poll the flags. Software clears a flag by writing a 0 to it. A flag that software does not clear keeps requesting, even while the service routine runs. When the core accepts the interrupt it pulses an acknowledge, and the block clears the global enable. A return strobe sets the global enable again.

The register port is a plain single-cycle port with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. The read data is a combinational function of `reg_addr` and of the register state. The event, acknowledge and return inputs are single-cycle strobes with no handshake.

Top module: `irq_hub`

## Requirements
- R1: After reset every register reads 0x00 and `irq_req` is 0.
- R2: Register addresses are: 0 = control, 1 = peripheral flags 0, 2 = peripheral flags 1, 3 = peripheral enables 0, 4 = peripheral enables 1. Peripheral source k maps to bit k mod 8 of register k/8. Bits 4 to 7 of peripheral registers 1 have no source: they read 0 and writes to them are ignored.
- R3: An event pulse sets its flag at the next clock edge, whether or not its enable is set.
- R4: If an event and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R5: A register write stores the written value. With no write and no event, every flag holds its value, including across changes to the enable bits.
- R6: Control register layout: bits 2:0 are the core flags, bits 5:3 the core enables (bit 3+i enables flag i), bit 6 the peripheral enable and bit 7 the global enable. `irq_req` is high while the global enable is set and some core flag has its enable set.
- R7: A peripheral flag with its enable set raises `irq_req` only while both the peripheral enable and the global enable are set. The peripheral enable does not gate core sources.
- R8: While the global enable is 0, `irq_req` is 0.
- R9: An `irq_ack` pulse clears the global enable at the next edge. It has priority over a return strobe and over a control register write in the same cycle.
- R10: An `irq_ret` pulse with no acknowledge sets the global enable at the next edge. This takes priority over a control register write.
- R11: After the return, a flag that is still set and enabled raises `irq_req` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| core_evt | input | 3 | Event pulses of the core sources |
| periph_evt | input | 12 | Event pulses of the peripheral sources |
| irq_ack | input | 1 | Interrupt accepted by the core |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Merged interrupt request |

## Verification
The hardest cases to reach from the ports are collisions in a single cycle. One is an event pulse arriving in the same edge as the software write that clears its flag. The other is an acknowledge meeting a return strobe or a control register write. The bench drives each pair together in one cycle and then reads back the register. It also checks that a flag stays pending while its enable and the two gating levels are switched off and on again, checking the request line after each step.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [1:0] {
    KIND_CTRL  = 2'd0,
    KIND_PFLAG = 2'd1,
    KIND_PEN   = 2'd2,
    KIND_NONE  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_hub_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int N_REG  = 2,
  parameter int IDX_W  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam int FLAG_BASE = 1;
  localparam int EN_BASE   = 1 + N_REG;

  always_comb begin
    int a;
    a    = int'(addr);
    kind = KIND_NONE;
    idx  = '0;
    if (a == 0) begin
      kind = KIND_CTRL;
    end else if (a < EN_BASE) begin
      kind = KIND_PFLAG;
      idx  = IDX_W'(a - FLAG_BASE);
    end else if (a < EN_BASE + N_REG) begin
      kind = KIND_PEN;
      idx  = IDX_W'(a - EN_BASE);
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_CORE = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [N_CORE-1:0] evt,
  input  logic              ack,
  input  logic              ret,
  output logic [N_CORE-1:0] flag,
  output logic [N_CORE-1:0] en,
  output logic              pen,
  output logic              gie,
  output logic [REG_W-1:0]  rdata
);
  localparam int EN_LSB  = N_CORE;
  localparam int PEN_BIT = 2 * N_CORE;
  localparam int GIE_BIT = 2 * N_CORE + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
      pen  <= 1'b0;
      gie  <= 1'b0;
    end else begin
      flag <= (wr ? wdata[N_CORE-1:0] : flag) | evt;
      if (wr) begin
        en  <= wdata[EN_LSB +: N_CORE];
        pen <= wdata[PEN_BIT];
      end
      if (ack)      gie <= 1'b0;
      else if (ret) gie <= 1'b1;
      else if (wr)  gie <= wdata[GIE_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[N_CORE-1:0]         = flag;
    rdata[EN_LSB +: N_CORE]   = en;
    rdata[PEN_BIT]            = pen;
    rdata[GIE_BIT]            = gie;
  end

  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !gie); // R9
  AST_RET_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack) |=> gie); // R10
  AST_CORE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag & $past(evt)) == $past(evt))); // R4
endmodule

// File: rtl/irq_pbank.sv
module irq_pbank #(
  parameter int N_SRC = 12,
  parameter int REG_W = 8,
  parameter int N_REG = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_REG-1:0]       wr_flag,
  input  logic [N_REG-1:0]       wr_en,
  input  logic [REG_W-1:0]       wdata,
  input  logic [N_SRC-1:0]       evt,
  output logic [N_SRC-1:0]       flag,
  output logic [N_SRC-1:0]       en,
  output logic [N_REG*REG_W-1:0] flag_pad,
  output logic [N_REG*REG_W-1:0] en_pad
);
  localparam int PAD = N_REG * REG_W;
  localparam logic [PAD-1:0] MASK = ~({PAD{1'b1}} << N_SRC);

  logic [PAD-1:0]   evt_pad;
  logic [REG_W-1:0] flag_r [N_REG];
  logic [REG_W-1:0] en_r   [N_REG];

  assign evt_pad = PAD'(evt);

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    localparam logic [REG_W-1:0] M = MASK[r*REG_W +: REG_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_r[r] <= '0;
        en_r[r]   <= '0;
      end else begin
        flag_r[r] <= ((wr_flag[r] ? wdata : flag_r[r]) | evt_pad[r*REG_W +: REG_W]) & M;
        if (wr_en[r]) en_r[r] <= wdata & M;
      end
    end
    assign flag_pad[r*REG_W +: REG_W] = flag_r[r];
    assign en_pad[r*REG_W +: REG_W]   = en_r[r];
  end

  assign flag = flag_pad[N_SRC-1:0];
  assign en   = en_pad[N_SRC-1:0];

  AST_PFLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flag & $past(evt)) == $past(evt))); // R4
  AST_PFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag == '0 && evt == '0) |=> $stable(flag)); // R5
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_pad & ~MASK) == '0) && ((en_pad & ~MASK) == '0)); // R2
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_CORE = 3,
  parameter int N_SRC  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORE-1:0] core_flag,
  input  logic [N_CORE-1:0] core_en,
  input  logic [N_SRC-1:0]  p_flag,
  input  logic [N_SRC-1:0]  p_en,
  input  logic              pen,
  input  logic              gie,
  output logic              req
);
  logic core_hit, periph_hit;

  assign core_hit   = |(core_flag & core_en);
  assign periph_hit = pen & |(p_flag & p_en);
  assign req        = gie & (core_hit | periph_hit);

  AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !req); // R8
  AST_PEN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pen && (core_flag & core_en) == '0) |-> !req); // R7
  AST_CORE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && (core_flag & core_en) != '0) |-> req); // R6
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_CORE  = 3,
  parameter int N_PERIPH = 12,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [N_CORE-1:0]   core_evt,
  input  logic [N_PERIPH-1:0] periph_evt,
  input  logic                irq_ack,
  input  logic                irq_ret,
  output logic                irq_req
);
  localparam int N_REG = (N_PERIPH + REG_W - 1) / REG_W;
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1;
  localparam int PAD   = N_REG * REG_W;

  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  logic [N_REG-1:0]   sel_onehot, wr_flag, wr_en;
  logic               wr_ctrl;
  logic [N_CORE-1:0]  c_flag, c_en;
  logic               pen, gie;
  logic [REG_W-1:0]   ctrl_rd;
  logic [N_PERIPH-1:0] p_flag, p_en;
  logic [PAD-1:0]     p_flag_pad, p_en_pad;

  irq_addr_dec #(.ADDR_W(ADDR_W), .N_REG(N_REG), .IDX_W(IDX_W)) u_dec (
    .addr(reg_addr), .kind(kind), .idx(idx)
  );

  assign sel_onehot = N_REG'(1) << idx;
  assign wr_ctrl    = reg_wr && (kind == KIND_CTRL);
  assign wr_flag    = (reg_wr && kind == KIND_PFLAG) ? sel_onehot : '0;
  assign wr_en      = (reg_wr && kind == KIND_PEN)   ? sel_onehot : '0;

  irq_ctrl #(.N_CORE(N_CORE), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(reg_wdata), .evt(core_evt),
    .ack(irq_ack), .ret(irq_ret), .flag(c_flag), .en(c_en), .pen(pen),
    .gie(gie), .rdata(ctrl_rd)
  );

  irq_pbank #(.N_SRC(N_PERIPH), .REG_W(REG_W), .N_REG(N_REG)) u_pbank (
    .clk(clk), .rst_n(rst_n), .wr_flag(wr_flag), .wr_en(wr_en),
    .wdata(reg_wdata), .evt(periph_evt), .flag(p_flag), .en(p_en),
    .flag_pad(p_flag_pad), .en_pad(p_en_pad)
  );

  irq_gate #(.N_CORE(N_CORE), .N_SRC(N_PERIPH)) u_gate (
    .clk(clk), .rst_n(rst_n), .core_flag(c_flag), .core_en(c_en),
    .p_flag(p_flag), .p_en(p_en), .pen(pen), .gie(gie), .req(irq_req)
  );

  always_comb begin
    unique case (kind)
      KIND_CTRL:  reg_rdata = ctrl_rd;
      KIND_PFLAG: reg_rdata = p_flag_pad[idx*REG_W +: REG_W];
      KIND_PEN:   reg_rdata = p_en_pad[idx*REG_W +: REG_W];
      default:    reg_rdata = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !irq_req); // R1
  AST_ACK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_req); // R9
endmodule

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [2:0]  core_evt = '0;
  logic [11:0] periph_evt = '0;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        irq_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_hub dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_evt(core_evt),
    .periph_evt(periph_evt), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req)
  );

  // vector: wr, addr, wdata, core_evt, periph_evt, read addr, exp rdata, exp irq
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 3'b001, 12'h000, 3'd0, 8'h01, 1'b0}, // R3 core flag w/o enable
    {1'b1, 3'd0, 8'h09, 3'b000, 12'h000, 3'd0, 8'h09, 1'b0}, // R8 enabled but gie off
    {1'b1, 3'd0, 8'h89, 3'b000, 12'h000, 3'd0, 8'h89, 1'b1}, // R6 core request
    {1'b1, 3'd0, 8'h88, 3'b000, 12'h000, 3'd0, 8'h88, 1'b0}, // R5 software clear
    {1'b0, 3'd0, 8'h00, 3'b000, 12'h001, 3'd1, 8'h01, 1'b0}, // R3 periph flag
    {1'b1, 3'd3, 8'h01, 3'b000, 12'h000, 3'd3, 8'h01, 1'b0}, // R7 pen off
    {1'b1, 3'd0, 8'hC8, 3'b000, 12'h000, 3'd0, 8'hC8, 1'b1}, // R7 pen on
    {1'b1, 3'd0, 8'h48, 3'b000, 12'h000, 3'd0, 8'h48, 1'b0}, // R8 gie off
    {1'b1, 3'd3, 8'h00, 3'b000, 12'h000, 3'd1, 8'h01, 1'b0}, // R5 pending survives
    {1'b1, 3'd0, 8'hC8, 3'b000, 12'h000, 3'd0, 8'hC8, 1'b0}, // R7 source enable off
    {1'b1, 3'd3, 8'h01, 3'b000, 12'h000, 3'd1, 8'h01, 1'b1}, // R5 re-enable fires
    {1'b1, 3'd1, 8'h00, 3'b000, 12'h001, 3'd1, 8'h01, 1'b1}, // R4 set beats clear
    {1'b1, 3'd1, 8'h00, 3'b000, 12'h000, 3'd1, 8'h00, 1'b0}, // R5 clear
    {1'b0, 3'd0, 8'h00, 3'b000, 12'h800, 3'd2, 8'h08, 1'b0}, // R2 source 11 position
    {1'b1, 3'd4, 8'hFF, 3'b000, 12'h000, 3'd4, 8'h0F, 1'b1}, // R2 unused bits
    {1'b1, 3'd2, 8'h00, 3'b000, 12'h000, 3'd2, 8'h00, 1'b0}, // R5 clear reg 1
    {1'b1, 3'd0, 8'hC8, 3'b001, 12'h000, 3'd0, 8'hC9, 1'b1}  // R4 core set beats write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [7:0] d,
                      input logic [2:0] ce, input logic [11:0] pe,
                      input logic ack, input logic ret, input logic [2:0] ra);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; core_evt = ce; periph_evt = pe;
    irq_ack = ack; irq_ret = ret;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; core_evt = '0; periph_evt = '0; irq_ack = 1'b0; irq_ret = 1'b0;
    reg_addr = ra;
    #0.5;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, registers and request
    for (int a = 0; a < 5; a++) begin
      reg_addr = 3'(a);
      #0.5;
      check("R1 reset reg", reg_rdata, 8'h00);
    end
    check("R1 reset irq", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      step(v[38], v[37:35], v[34:27], v[26:24], v[23:12], 1'b0, 1'b0, v[11:9]);
      check($sformatf("vector %0d rdata", i), reg_rdata, v[8:1]);
      check($sformatf("vector %0d irq", i), {7'd0, irq_req}, {7'd0, v[0]});
    end

    // state now: CTRL = 0xC9 (core 0 flag+enable, pen, gie), request active
    step(1'b0, 3'd0, 8'h00, 3'd0, 12'h0, 1'b1, 1'b0, 3'd0);
    check("R9 ack clears gie", reg_rdata, 8'h49);
    check("R9 ack drops irq", {7'd0, irq_req}, 8'h00);
    step(1'b0, 3'd0, 8'h00, 3'd0, 12'h0, 1'b0, 1'b1, 3'd0);
    check("R10 ret sets gie", reg_rdata, 8'hC9);
    check("R11 pending flag requests again", {7'd0, irq_req}, 8'h01);
    step(1'b0, 3'd0, 8'h00, 3'd0, 12'h0, 1'b1, 1'b1, 3'd0);
    check("R9 ack beats ret", reg_rdata, 8'h49);
    step(1'b1, 3'd0, 8'hC9, 3'd0, 12'h0, 1'b1, 1'b0, 3'd0);
    check("R9 ack beats write", reg_rdata, 8'h49);
    step(1'b1, 3'd0, 8'h49, 3'd0, 12'h0, 1'b0, 1'b1, 3'd0);
    check("R10 ret beats write", reg_rdata, 8'hC9);
    // R7 peripheral enable does not gate core sources
    step(1'b1, 3'd0, 8'h89, 3'd0, 12'h0, 1'b0, 1'b0, 3'd0);
    check("R7 core ignores pen", {7'd0, irq_req}, 8'h01);
    // R2 unused address reads zero
    reg_addr = 3'd6;
    #0.5;
    check("R2 unmapped address", reg_rdata, 8'h00);

    finish_run();
  end
endmodule